// File: doc/BRIEF.md
# Asynchronous Interrupt Pending Arbiter

This block sits between a core's asynchronous interrupt sources and its exception entry logic. It keeps the pending state of a level-sensitive external interrupt line and of decrementer underflow events. It combines these with the machine-state enable bits and the floating-point exception summary to decide which cause, if any, must be taken next. When the core reaches an instruction boundary and a source qualifies, the block raises a single delivery request. The request carries the cause code, the vector offset and the extra save/restore flags that the entry logic needs. The request stays up until the entry logic acknowledges it.

The external line is reported through an event strobe that carries the new level of the line. The decrementer delivers a one-cycle underflow pulse. The block owns neither the decrementer counter nor the state update done on exception entry.

Top module: `irq_arb_top`

## Requirements
- R1: Synchronous reset drives `req_o`, `cause_o`, `offset_o`, `flags_o` and `dup_err_o` to zero and clears both pending bits.
- R2: A floating-point enabled exception qualifies when (`fe0_i` or `fe1_i`) and `fp_sum_i` are high, whatever the value of `ee_i`. It outranks every other source. It is delivered with cause 1, offset 0x700 and `flags_o` = 2'b11 (bit 0 marks an enabled floating-point exception, bit 1 marks that the save address points at the next instruction).
- R3: When `ee_i` is high and external is pending, external is delivered with cause 2, offset 0x500 and flags 0. External is chosen ahead of a pending decrementer.
- R4: An event with `ext_lvl_i`=1 sets the external pending bit, and only an event with `ext_lvl_i`=0 clears it. Delivering and acknowledging the external cause leaves it pending, so the next boundary requests it again.
- R5: A `dec_pulse_i` latches decrementer pending. The decrementer is delivered with cause 3, offset 0x900 and flags 0. Issuing its request consumes the pending bit, so each underflow is taken once.
- R6: While `ee_i` is low, external and decrementer requests are held off and their pending bits are kept. Once `ee_i` is high they are delivered at the next boundary.
- R7: A request rises only in the cycle after a cycle with `boundary_i` high and no request outstanding. While the request is outstanding its cause, offset and flags hold steady, and no other request is issued. The cycle after `ack_i`, `req_o` is low.
- R8: While `req_o` is low, `cause_o` is 0 (no cause), `offset_o` is 0 and `flags_o` is 0. A boundary with no qualifying source raises no request.
- R9: An event with `ext_lvl_i`=1 while external is already pending and `ee_i` is high raises `dup_err_o` for the one following cycle. In every other case `dup_err_o` stays low, and such an event never creates an extra request.
- R10: If a `dec_pulse_i` arrives in the same cycle that a decrementer request is issued, decrementer stays pending and is delivered again after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_evt_i | input | 1 | Strobe: external line changed, new level on ext_lvl_i |
| ext_lvl_i | input | 1 | Level of the external interrupt line at the event |
| dec_pulse_i | input | 1 | Decrementer underflow event, one cycle |
| ee_i | input | 1 | External interrupt enable from machine state |
| fe0_i | input | 1 | Floating-point exception mode bit 0 |
| fe1_i | input | 1 | Floating-point exception mode bit 1 |
| fp_sum_i | input | 1 | Floating-point status enabled-exception summary |
| boundary_i | input | 1 | Instruction boundary strobe |
| ack_i | input | 1 | Entry logic has taken the request |
| req_o | output | 1 | Delivery request outstanding |
| cause_o | output | 2 | Chosen cause: 0 none, 1 FP enabled, 2 external, 3 decrementer |
| offset_o | output | 12 | Vector offset of the chosen cause |
| flags_o | output | 2 | Extra save/restore flags for the chosen cause |
| dup_err_o | output | 1 | Repeated external assertion while enabled |

## Verification
The assertions assume that `ack_i` is raised only while a request is outstanding, and that `dec_pulse_i` and `ext_evt_i` are single-cycle strobes. They also assume that the enable and floating-point inputs hold steady around each boundary. The directed tasks drive every strobe for exactly one cycle, change inputs only on the falling edge, and acknowledge only after they have seen the request. The duplicate-assertion check is the one place where a repeated raise of an already-pending line is driven on purpose.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    parameter int unsigned OFF_W  = 12;
    parameter int unsigned FLAG_W = 2;

    localparam int unsigned FLG_FPEN = 0;
    localparam int unsigned FLG_NEXT = 1;

    localparam logic [OFF_W-1:0] VEC_FPX = OFF_W'(12'h700);
    localparam logic [OFF_W-1:0] VEC_EXT = OFF_W'(12'h500);
    localparam logic [OFF_W-1:0] VEC_DEC = OFF_W'(12'h900);

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_FPX  = 2'd1,
        CAUSE_EXT  = 2'd2,
        CAUSE_DEC  = 2'd3
    } cause_e;

    typedef struct packed {
        cause_e              cause;
        logic [OFF_W-1:0]    offset;
        logic [FLAG_W-1:0]   flags;
    } grant_t;

    function automatic grant_t make_grant(cause_e c);
        grant_t g;
        g = '0;
        g.cause = c;
        case (c)
            CAUSE_FPX: begin
                g.offset = VEC_FPX;
                g.flags[FLG_FPEN] = 1'b1;
                g.flags[FLG_NEXT] = 1'b1;
            end
            CAUSE_EXT: g.offset = VEC_EXT;
            CAUSE_DEC: g.offset = VEC_DEC;
            default:   g.offset = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track (
    input  logic clk,
    input  logic rst,
    input  logic ext_evt_i,
    input  logic ext_lvl_i,
    input  logic dec_pulse_i,
    input  logic dec_take_i,
    input  logic ee_i,
    output logic ext_pend_o,
    output logic dec_pend_o,
    output logic dup_err_o
);

    logic ext_q, dec_q, dup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            dec_q <= 1'b0;
            dup_q <= 1'b0;
        end else begin
            if (ext_evt_i) begin
                ext_q <= ext_lvl_i;
            end
            dup_q <= ext_evt_i & ext_lvl_i & ext_q & ee_i;
            dec_q <= dec_pulse_i | (dec_q & ~dec_take_i);
        end
    end

    assign ext_pend_o = ext_q;
    assign dec_pend_o = dec_q;
    assign dup_err_o  = dup_q;

    AST_EXT_DROP: assert property (@(posedge clk) disable iff (rst)
        (ext_evt_i && !ext_lvl_i) |=> !ext_pend_o); // R4
    AST_EXT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ext_pend_o && !ext_evt_i) |=> ext_pend_o); // R4
    AST_DEC_ONCE: assert property (@(posedge clk) disable iff (rst)
        (dec_take_i && !dec_pulse_i) |=> !dec_pend_o); // R5
    AST_DEC_REARM: assert property (@(posedge clk) disable iff (rst)
        dec_pulse_i |=> dec_pend_o); // R10
    AST_DUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ext_evt_i || !ee_i) |=> !dup_err_o); // R9

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_arb_pkg::*;
(
    input  logic   fe0_i,
    input  logic   fe1_i,
    input  logic   fp_sum_i,
    input  logic   ee_i,
    input  logic   ext_pend_i,
    input  logic   dec_pend_i,
    output logic   any_o,
    output grant_t grant_o
);

    logic fpx_ok, ext_ok, dec_ok;

    always_comb begin
        fpx_ok = (fe0_i | fe1_i) & fp_sum_i;
        ext_ok = ee_i & ext_pend_i;
        dec_ok = ee_i & dec_pend_i;
        any_o  = fpx_ok | ext_ok | dec_ok;
        if (fpx_ok) begin
            grant_o = make_grant(CAUSE_FPX);
        end else if (ext_ok) begin
            grant_o = make_grant(CAUSE_EXT);
        end else if (dec_ok) begin
            grant_o = make_grant(CAUSE_DEC);
        end else begin
            grant_o = make_grant(CAUSE_NONE);
        end
    end

endmodule

// File: rtl/irq_issue.sv
module irq_issue
    import irq_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   boundary_i,
    input  logic   ack_i,
    input  logic   any_i,
    input  grant_t grant_i,
    output logic   fire_o,
    output logic   req_o,
    output grant_t grant_o
);

    logic   req_q;
    grant_t g_q;

    assign fire_o = boundary_i & ~req_q & any_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            g_q   <= '0;
        end else if (fire_o) begin
            req_q <= 1'b1;
            g_q   <= grant_i;
        end else if (req_q && ack_i) begin
            req_q <= 1'b0;
            g_q   <= '0;
        end
    end

    assign req_o   = req_q;
    assign grant_o = g_q;

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> (req_o && $stable(grant_o))); // R7
    AST_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(boundary_i)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i) |=> !req_o); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (grant_o.cause == CAUSE_NONE && grant_o.offset == '0
                    && grant_o.flags == '0)); // R8

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_evt_i,
    input  logic              ext_lvl_i,
    input  logic              dec_pulse_i,
    input  logic              ee_i,
    input  logic              fe0_i,
    input  logic              fe1_i,
    input  logic              fp_sum_i,
    input  logic              boundary_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [1:0]        cause_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              dup_err_o
);

    logic   ext_pend, dec_pend, any_ok, fire, dec_take;
    grant_t sel_g, out_g;

    irq_pend_track u_pend (
        .clk         (clk),
        .rst         (rst),
        .ext_evt_i   (ext_evt_i),
        .ext_lvl_i   (ext_lvl_i),
        .dec_pulse_i (dec_pulse_i),
        .dec_take_i  (dec_take),
        .ee_i        (ee_i),
        .ext_pend_o  (ext_pend),
        .dec_pend_o  (dec_pend),
        .dup_err_o   (dup_err_o)
    );

    irq_prio_sel u_sel (
        .fe0_i      (fe0_i),
        .fe1_i      (fe1_i),
        .fp_sum_i   (fp_sum_i),
        .ee_i       (ee_i),
        .ext_pend_i (ext_pend),
        .dec_pend_i (dec_pend),
        .any_o      (any_ok),
        .grant_o    (sel_g)
    );

    irq_issue u_issue (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary_i),
        .ack_i      (ack_i),
        .any_i      (any_ok),
        .grant_i    (sel_g),
        .fire_o     (fire),
        .req_o      (req_o),
        .grant_o    (out_g)
    );

    assign dec_take = fire & (sel_g.cause == CAUSE_DEC);

    assign cause_o  = out_g.cause;
    assign offset_o = out_g.offset;
    assign flags_o  = out_g.flags;

    AST_FP_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && $past((fe0_i || fe1_i) && fp_sum_i))
        |-> cause_o == CAUSE_FPX); // R2
    AST_EXT_OVER_DEC: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && $past(ee_i && ext_pend && !fp_sum_i))
        |-> cause_o == CAUSE_EXT); // R3
    AST_MASKED: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && $past(!ee_i)) |-> cause_o == CAUSE_FPX); // R6

endmodule

// File: tb/test_irq_arb_top.sv
module test_irq_arb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_evt = 0, ext_lvl = 0, dec_pulse = 0, ee = 0;
    logic        fe0 = 0, fe1 = 0, fp_sum = 0, boundary = 0, ack = 0;
    logic        req, dup_err;
    logic [1:0]  cause;
    logic [11:0] offset;
    logic [1:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    irq_arb_top i_irq_arb_top (
        .clk(clk), .rst(rst), .ext_evt_i(ext_evt), .ext_lvl_i(ext_lvl),
        .dec_pulse_i(dec_pulse), .ee_i(ee), .fe0_i(fe0), .fe1_i(fe1),
        .fp_sum_i(fp_sum), .boundary_i(boundary), .ack_i(ack),
        .req_o(req), .cause_o(cause), .offset_o(offset), .flags_o(flags),
        .dup_err_o(dup_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_grant(string tag, logic [1:0] c, logic [11:0] o, logic [1:0] f);
        chk({tag, " req"}, {31'd0, req}, 32'd1);
        chk({tag, " cause"}, {30'd0, cause}, {30'd0, c});
        chk({tag, " offset"}, {20'd0, offset}, {20'd0, o});
        chk({tag, " flags"}, {30'd0, flags}, {30'd0, f});
    endtask

    task automatic expect_idle(string tag);
        chk({tag, " req"}, {31'd0, req}, 32'd0);
        chk({tag, " cause"}, {30'd0, cause}, 32'd0);
        chk({tag, " offset"}, {20'd0, offset}, 32'd0);
        chk({tag, " flags"}, {30'd0, flags}, 32'd0);
    endtask

    task automatic at_boundary();
        boundary = 1; tick(); boundary = 0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic ext_event(logic l);
        ext_evt = 1; ext_lvl = l; tick(); ext_evt = 0; ext_lvl = 0;
    endtask

    task automatic dec_event();
        dec_pulse = 1; tick(); dec_pulse = 0;
    endtask

    task automatic t_reset();
        expect_idle("R1 reset");
        chk("R1 dup_err reset", {31'd0, dup_err}, 32'd0);
        at_boundary();
        expect_idle("R8 empty boundary");
    endtask

    task automatic t_external();
        ee = 1;
        ext_event(1);
        chk("R9 first raise no dup", {31'd0, dup_err}, 32'd0);
        at_boundary();
        expect_grant("R3 external", 2'd2, 12'h500, 2'd0);
        do_ack();
        expect_idle("R7 R8 after ack");
        at_boundary();
        expect_grant("R4 still pending", 2'd2, 12'h500, 2'd0);
        do_ack();
        ext_event(0);
        at_boundary();
        expect_idle("R4 line dropped");
        ee = 0;
    endtask

    task automatic t_decrementer();
        ee = 1;
        dec_event();
        at_boundary();
        expect_grant("R5 decrementer", 2'd3, 12'h900, 2'd0);
        do_ack();
        at_boundary();
        expect_idle("R5 consumed once");
        ee = 0;
    endtask

    task automatic t_masked();
        ee = 0;
        ext_event(1);
        dec_event();
        at_boundary();
        expect_idle("R6 masked");
        repeat (3) tick();
        ee = 1;
        at_boundary();
        expect_grant("R6 R3 ext before dec", 2'd2, 12'h500, 2'd0);
        do_ack();
        ext_event(0);
        at_boundary();
        expect_grant("R6 dec kept while masked", 2'd3, 12'h900, 2'd0);
        do_ack();
        ee = 0;
    endtask

    task automatic t_fp();
        ee = 0; fe0 = 1; fp_sum = 1;
        at_boundary();
        expect_grant("R2 fp with ee low", 2'd1, 12'h700, 2'd3);
        do_ack();
        fe0 = 0; fe1 = 1; ee = 1;
        ext_event(1);
        dec_event();
        at_boundary();
        expect_grant("R2 fp outranks ext", 2'd1, 12'h700, 2'd3);
        do_ack();
        fe1 = 0;
        at_boundary();
        expect_grant("R2 fe clear gives ext", 2'd2, 12'h500, 2'd0);
        do_ack();
        ext_event(0);
        at_boundary();
        expect_grant("R2 then dec", 2'd3, 12'h900, 2'd0);
        do_ack();
        fp_sum = 0; ee = 0;
    endtask

    task automatic t_hold();
        ee = 1;
        ext_event(1);
        repeat (4) tick();
        expect_idle("R7 no boundary no req");
        at_boundary();
        expect_grant("R7 raised", 2'd2, 12'h500, 2'd0);
        boundary = 1; fe0 = 1; fp_sum = 1;
        repeat (3) tick();
        boundary = 0; fe0 = 0; fp_sum = 0;
        expect_grant("R7 held without ack", 2'd2, 12'h500, 2'd0);
        do_ack();
        expect_idle("R7 cleared by ack");
        ext_event(0);
        ee = 0;
    endtask

    task automatic t_dup();
        ee = 1;
        ext_event(1);
        chk("R9 new raise", {31'd0, dup_err}, 32'd0);
        ext_event(1);
        chk("R9 dup flagged", {31'd0, dup_err}, 32'd1);
        tick();
        chk("R9 dup one cycle", {31'd0, dup_err}, 32'd0);
        at_boundary();
        expect_grant("R9 single request", 2'd2, 12'h500, 2'd0);
        do_ack();
        ee = 0;
        ext_event(1);
        chk("R9 masked no dup", {31'd0, dup_err}, 32'd0);
        ext_event(0);
    endtask

    task automatic t_same_cycle();
        ee = 1;
        dec_event();
        boundary = 1; dec_pulse = 1; tick(); boundary = 0; dec_pulse = 0;
        expect_grant("R10 first take", 2'd3, 12'h900, 2'd0);
        do_ack();
        at_boundary();
        expect_grant("R10 rearmed", 2'd3, 12'h900, 2'd0);
        do_ack();
        at_boundary();
        expect_idle("R10 then empty");
        ee = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_external();
        t_decrementer();
        t_masked();
        t_fp();
        t_hold();
        t_dup();
        t_same_cycle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule